// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Event Detection

The block is a 32-pin general-purpose I/O bank controlled through a simple word-addressed register bus. Each pin is driven from an output data register when its direction bit selects output. Each input is passed through a two-flop synchroniser and then, if the pin asks for it, through a debounce filter that accepts a new level only after it has stayed stable for a programmable number of prescaler ticks. The filtered level feeds four detectors per pin: low level, high level, rising edge and falling edge, each with its own enable. Any enabled detector sets the pin's bit in a shared event vector. Two interrupt lines, A and B, each have their own enable mask. A third mask drives a wake request.

Output data, the two interrupt masks and the wake mask can be changed atomically through set and clear alias addresses. Event bits are cleared by writing ones to a masked-status address, and software can raise event bits by writing ones to a raw-status address. A soft reset is run by a small sequencer with three states. RS_CLEAR returns every register to its reset value for one cycle and then always moves to RS_FLUSH. RS_FLUSH lets the synchroniser and filter pipeline refill for SETTLE cycles while detection and bus writes are held off, then moves to RS_READY. RS_READY is the normal operating state, and a soft-reset write takes it back to RS_CLEAR. SETTLE must be at least 4, so that no false edge appears when the bank leaves the flush.

Top module: `gpio_event_bank`

## Requirements
- R1: After reset and once ready, the direction register (0x02) reads all ones and `pad_oe` is all zero. Output data (0x04), event vector (0x10) and every enable read zero. `irq_a`, `irq_b` and `wake_req` are low. The status register (0x01) bit 0 reads 1.
- R2: A write to 0x04 sets `pad_out` at the next clock edge, and `pad_out` changes at no other time. A direction bit of 0 (written at 0x02) makes `pad_oe` 1 for that pin.
- R3: Writing ones to 0x05 sets those output data bits, and writing ones to 0x06 clears them. Bits written 0 are untouched. Both aliases read back the output data.
- R4: The input data register (0x03) shows a pad level after the third rising clock edge following the change, on a pin without debounce.
- R5: With the rising-edge enable (0x09) set, a 0-to-1 change of the filtered level sets the pin's event bit, and the bit stays set until it is cleared.
- R6: With the falling-edge enable (0x0A) set, a 1-to-0 change of the filtered level sets the pin's event bit, and the bit stays set until it is cleared.
- R7: With the low-level enable (0x07) or the high-level enable (0x08) set, the event bit is set again on every cycle while the matching level lasts, so it reappears after a clear.
- R8: Writing ones to 0x12 or 0x13 clears those event bits. If a detector sets a bit in the same cycle as it is cleared, the bit stays set.
- R9: Line A enable bits are set by ones at 0x14 and cleared by ones at 0x15, and line B uses 0x16 and 0x17. Zeros have no effect. Address 0x12 reads events AND enable A, and 0x13 reads events AND enable B. `irq_a` and `irq_b` are high exactly when their masked view is non-zero.
- R10: Wake enable bits are set by ones at 0x18 and cleared by ones at 0x19. `wake_req` is high exactly when the event vector AND the wake enables is non-zero.
- R11: Writing ones to 0x10 or 0x11 sets those event bits. Both addresses read the same event vector.
- R12: For a pin with debounce enabled (0x0B), with time T at 0x0C bits 7:0, a filtered level changes only after the synchronised input has differed from it for T+1 ticks of a prescaler that ticks every TICK_CYCLES clocks. A pulse shorter than T*TICK_CYCLES clocks is dropped.
- R13: Writing 1 to bit 0 of 0x00 makes status bit 0 read 0 in the next cycle, returns all registers and events to their reset values, and status bit 0 reads 1 again within SETTLE+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Output data to the pads |
| pad_oe | output | 32 | Per-pin output drive enable, 1 = drive |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |
| wake_req | output | 1 | Wake request |

## Verification
A hardware detection and a software write-one-to-clear of the same event bit can fall on the same clock edge. The bench provokes this by presetting the bit from software, raising a pad with the rising detector enabled, and placing the clear write exactly on the edge where the filtered level first differs from its previous value. It judges the result by reading the event vector: the bit must still be set. A second clear one cycle later must remove it. Level and edge detectors are also swept over all sixteen enable combinations, with expected bits computed from the enable pattern.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG      = 5'h00,
        A_STAT     = 5'h01,
        A_DIR      = 5'h02,
        A_DIN      = 5'h03,
        A_DOUT     = 5'h04,
        A_DOUT_SET = 5'h05,
        A_DOUT_CLR = 5'h06,
        A_DET_LOW  = 5'h07,
        A_DET_HIGH = 5'h08,
        A_DET_RISE = 5'h09,
        A_DET_FALL = 5'h0A,
        A_DB_EN    = 5'h0B,
        A_DB_TIME  = 5'h0C,
        A_RAW_A    = 5'h10,
        A_RAW_B    = 5'h11,
        A_STS_A    = 5'h12,
        A_STS_B    = 5'h13,
        A_ENA_SET  = 5'h14,
        A_ENA_CLR  = 5'h15,
        A_ENB_SET  = 5'h16,
        A_ENB_CLR  = 5'h17,
        A_WK_SET   = 5'h18,
        A_WK_CLR   = 5'h19
    } reg_addr_e;

    typedef enum logic [1:0] {
        RS_CLEAR,
        RS_FLUSH,
        RS_READY
    } rst_state_e;

endpackage

// File: rtl/gpio_rst_seq.sv
module gpio_rst_seq
    import gpio_bank_pkg::*;
#(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_req,
    output logic clr_o,
    output logic ready_o
);

    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    rst_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_CLEAR;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_CLEAR: st_d = RS_FLUSH;
            RS_FLUSH: if (cnt_q == CW'(SETTLE - 1)) st_d = RS_READY;
            RS_READY: if (soft_req) st_d = RS_CLEAR;
            default:  st_d = RS_CLEAR;
        endcase
    end

    // flush length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (st_q != RS_FLUSH) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        clr_o   = (st_q == RS_CLEAR);
        ready_o = (st_q == RS_READY);
    end

    // R13
    soft_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_req |=> !ready_o);

endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
    parameter int NPINS       = 32,
    parameter int DBW         = 8,
    parameter int TICK_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NPINS-1:0] pad_i,
    input  logic [NPINS-1:0] db_en_i,
    input  logic [DBW-1:0]   db_time_i,
    output logic [NPINS-1:0] filt_o
);

    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [PW-1:0]    pre_q;
    logic             tick;
    logic [NPINS-1:0] s1_q, s2_q;

    assign tick = (pre_q == PW'(TICK_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre_q <= '0;
        else if (clr)  pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (clr) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= pad_i;
            s2_q <= s1_q;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [DBW-1:0] cnt_q;
        logic           lvl_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
                lvl_q <= 1'b0;
            end else if (clr) begin
                cnt_q <= '0;
                lvl_q <= 1'b0;
            end else if (!db_en_i[i]) begin
                cnt_q <= '0;
                lvl_q <= s2_q[i];
            end else if (s2_q[i] == lvl_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == db_time_i) begin
                    cnt_q <= '0;
                    lvl_q <= s2_q[i];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end

        assign filt_o[i] = lvl_q;
    end

    // R12
    db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !$past(clr) |->
        (((filt_o ^ $past(filt_o)) & $past(db_en_i & ~(s2_q ^ filt_o))) == '0));

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ready_i,
    input  logic [NPINS-1:0] filt_i,
    input  logic [NPINS-1:0] det_low_i,
    input  logic [NPINS-1:0] det_high_i,
    input  logic [NPINS-1:0] det_rise_i,
    input  logic [NPINS-1:0] det_fall_i,
    input  logic [NPINS-1:0] sw_set_i,
    input  logic [NPINS-1:0] w1c_i,
    output logic [NPINS-1:0] ev_o
);

    logic [NPINS-1:0] prev_q, hw_set, ev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     prev_q <= '0;
        else if (clr_i) prev_q <= '0;
        else            prev_q <= filt_i;
    end

    always_comb begin
        if (ready_i)
            hw_set = (~filt_i & det_low_i) | (filt_i & det_high_i)
                   | (filt_i & ~prev_q & det_rise_i)
                   | (~filt_i & prev_q & det_fall_i);
        else
            hw_set = '0;
    end

    // hardware and software set take precedence over write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ev_q <= '0;
        else if (clr_i) ev_q <= '0;
        else            ev_q <= (ev_q & ~w1c_i) | hw_set | sw_set_i;
    end

    assign ev_o = ev_q;

    // R5
    ev_latch_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        ((ev_q & ~w1c_i) != '0) |=>
        ((ev_q & $past(ev_q & ~w1c_i)) == $past(ev_q & ~w1c_i)));

    // R7
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (ready_i && ((det_high_i & filt_i) != '0)) |=>
        ((ev_q & $past(det_high_i & filt_i)) == $past(det_high_i & filt_i)));

endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int DBW         = 8,
    parameter int TICK_CYCLES = 8,
    parameter int SETTLE      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_a,
    output logic              irq_b,
    output logic              wake_req
);

    logic             clr, ready, wr, soft_req;
    reg_addr_e        addr;
    logic [NPINS-1:0] dir_q, dout_q, dlow_q, dhigh_q, drise_q, dfall_q;
    logic [NPINS-1:0] db_en_q, en_a_q, en_b_q, wake_q;
    logic [DBW-1:0]   db_time_q;
    logic [NPINS-1:0] filt, ev, sw_set, w1c;

    assign addr     = reg_addr_e'(bus_addr);
    assign wr       = bus_en && bus_we && ready;
    assign soft_req = wr && (addr == A_CFG) && bus_wdata[0];
    assign sw_set   = (wr && (addr == A_RAW_A || addr == A_RAW_B)) ? bus_wdata : '0;
    assign w1c      = (wr && (addr == A_STS_A || addr == A_STS_B)) ? bus_wdata : '0;

    gpio_rst_seq #(.SETTLE(SETTLE)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_req (soft_req),
        .clr_o    (clr),
        .ready_o  (ready)
    );

    gpio_in_filter #(.NPINS(NPINS), .DBW(DBW), .TICK_CYCLES(TICK_CYCLES)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .pad_i     (pad_in),
        .db_en_i   (db_en_q),
        .db_time_i (db_time_q),
        .filt_o    (filt)
    );

    gpio_event_detect #(.NPINS(NPINS)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .ready_i    (ready),
        .filt_i     (filt),
        .det_low_i  (dlow_q),
        .det_high_i (dhigh_q),
        .det_rise_i (drise_q),
        .det_fall_i (dfall_q),
        .sw_set_i   (sw_set),
        .w1c_i      (w1c),
        .ev_o       (ev)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;  dout_q <= '0;  dlow_q <= '0;  dhigh_q <= '0;
            drise_q <= '0; dfall_q <= '0; db_en_q <= '0; db_time_q <= '0;
            en_a_q <= '0; en_b_q <= '0;  wake_q <= '0;
        end else if (clr) begin
            dir_q <= '1;  dout_q <= '0;  dlow_q <= '0;  dhigh_q <= '0;
            drise_q <= '0; dfall_q <= '0; db_en_q <= '0; db_time_q <= '0;
            en_a_q <= '0; en_b_q <= '0;  wake_q <= '0;
        end else if (wr) begin
            case (addr)
                A_DIR:      dir_q     <= bus_wdata;
                A_DOUT:     dout_q    <= bus_wdata;
                A_DOUT_SET: dout_q    <= dout_q | bus_wdata;
                A_DOUT_CLR: dout_q    <= dout_q & ~bus_wdata;
                A_DET_LOW:  dlow_q    <= bus_wdata;
                A_DET_HIGH: dhigh_q   <= bus_wdata;
                A_DET_RISE: drise_q   <= bus_wdata;
                A_DET_FALL: dfall_q   <= bus_wdata;
                A_DB_EN:    db_en_q   <= bus_wdata;
                A_DB_TIME:  db_time_q <= bus_wdata[DBW-1:0];
                A_ENA_SET:  en_a_q    <= en_a_q | bus_wdata;
                A_ENA_CLR:  en_a_q    <= en_a_q & ~bus_wdata;
                A_ENB_SET:  en_b_q    <= en_b_q | bus_wdata;
                A_ENB_CLR:  en_b_q    <= en_b_q & ~bus_wdata;
                A_WK_SET:   wake_q    <= wake_q | bus_wdata;
                A_WK_CLR:   wake_q    <= wake_q & ~bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_STAT:                bus_rdata = NPINS'(ready);
            A_DIR:                 bus_rdata = dir_q;
            A_DIN:                 bus_rdata = filt;
            A_DOUT, A_DOUT_SET,
            A_DOUT_CLR:            bus_rdata = dout_q;
            A_DET_LOW:             bus_rdata = dlow_q;
            A_DET_HIGH:            bus_rdata = dhigh_q;
            A_DET_RISE:            bus_rdata = drise_q;
            A_DET_FALL:            bus_rdata = dfall_q;
            A_DB_EN:               bus_rdata = db_en_q;
            A_DB_TIME:             bus_rdata = NPINS'(db_time_q);
            A_RAW_A, A_RAW_B:      bus_rdata = ev;
            A_STS_A:               bus_rdata = ev & en_a_q;
            A_STS_B:               bus_rdata = ev & en_b_q;
            A_ENA_SET, A_ENA_CLR:  bus_rdata = en_a_q;
            A_ENB_SET, A_ENB_CLR:  bus_rdata = en_b_q;
            A_WK_SET, A_WK_CLR:    bus_rdata = wake_q;
            default:               bus_rdata = '0;
        endcase
    end

    assign pad_out  = dout_q;
    assign pad_oe   = ~dir_q;
    assign irq_a    = |(ev & en_a_q);
    assign irq_b    = |(ev & en_b_q);
    assign wake_req = |(ev & wake_q);

    // R3
    dout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_DOUT_SET) |=> ((dout_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(wr && (addr == A_DOUT || addr == A_DOUT_SET || addr == A_DOUT_CLR)))
        |=> $stable(pad_out));

endmodule

// File: tb/gpio_event_bank_test.sv
module gpio_event_bank_test;

    localparam int N = 32;
    localparam logic [4:0] CFG = 5'h00, STAT = 5'h01, DIR = 5'h02, DIN = 5'h03,
        DOUT = 5'h04, DSET = 5'h05, DCLR = 5'h06, DLOW = 5'h07, DHIGH = 5'h08,
        DRISE = 5'h09, DFALL = 5'h0A, DBEN = 5'h0B, DBTIME = 5'h0C, RAWA = 5'h10,
        RAWB = 5'h11, STSA = 5'h12, STSB = 5'h13, ENAS = 5'h14, ENAC = 5'h15,
        ENBS = 5'h16, ENBC = 5'h17, WKS = 5'h18, WKC = 5'h19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [N-1:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
    logic irq_a, irq_b, wake_req;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gpio_event_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [4:0] a, output logic [N-1:0] d);
        bus_addr = a; bus_we = 1'b0; bus_en = 1'b1;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic wr_now(input logic [4:0] a, input logic [N-1:0] v);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1; bus_en = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] v);
        @(negedge clk);
        wr_now(a, v);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d, m, exp, ena, enb, wk, p;
        int polls;

        settle(3);
        rst_n = 1'b1;
        polls = 0;
        for (int t = 0; t < 20; t++) begin
            rd(STAT, d);
            polls++;
            if (d[0]) break;
        end
        // R1 reset state
        chk(d[0] == 1'b1, "R1 ready after reset", d, 1);
        rd(DIR, d);  chk(d == '1, "R1 dir reset", d, '1);
        chk(pad_oe == '0, "R1 pad_oe reset", pad_oe, 0);
        rd(DOUT, d); chk(d == '0 && pad_out == '0, "R1 dout reset", d, 0);
        rd(RAWA, d); chk(d == '0, "R1 events reset", d, 0);
        rd(ENAS, d); chk(d == '0, "R1 enable A reset", d, 0);
        chk({irq_a, irq_b, wake_req} == 3'b000, "R1 outputs low", {irq_a, irq_b, wake_req}, 0);

        // R4 exact latency of the input path
        @(negedge clk); pad_in = 32'hA5C3_0F96;
        @(negedge clk); @(negedge clk);
        peek(DIN, d); chk(d == '0, "R4 din before third edge", d, 0);
        @(negedge clk);
        peek(DIN, d); chk(d == 32'hA5C3_0F96, "R4 din at third edge", d, 32'hA5C3_0F96);
        for (int i = 0; i < N; i++) begin
            @(negedge clk); pad_in = 32'h1 << i;
            settle(3);
            peek(DIN, d); chk(d == (32'h1 << i), "R4 walking one", d, 32'h1 << i);
        end
        @(negedge clk); pad_in = '0; settle(6);

        // R2 direction and direct output data
        wr(DIR, 32'h0F0F_3355);
        chk(pad_oe == 32'hF0F0_CCAA, "R2 pad_oe from dir", pad_oe, 32'hF0F0_CCAA);
        @(negedge clk); bus_addr = DOUT; bus_wdata = 32'h1234_5678; bus_we = 1'b1; bus_en = 1'b1;
        #1 chk(pad_out == '0, "R2 pad_out before edge", pad_out, 0);
        @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
        chk(pad_out == 32'h1234_5678, "R2 pad_out after edge", pad_out, 32'h1234_5678);
        settle(3);
        chk(pad_out == 32'h1234_5678, "R2 pad_out held", pad_out, 32'h1234_5678);

        // R3 set and clear aliases, walking sweep
        m = 32'h1234_5678;
        for (int i = 0; i < N; i++) begin
            if (i % 3 == 0) begin
                wr(DCLR, 32'h8000_0001 << (i % 8));
                m = m & ~(32'h8000_0001 << (i % 8));
            end else begin
                wr(DSET, 32'h1 << i);
                m = m | (32'h1 << i);
            end
            chk(pad_out == m, "R3 alias update", pad_out, m);
        end
        rd(DSET, d); chk(d == m, "R3 set alias readback", d, m);
        rd(DCLR, d); chk(d == m, "R3 clear alias readback", d, m);
        wr(DOUT, '0);
        wr(DIR, '1);

        // R5 R6 R7 sweep over all detect enable combinations
        for (int k = 0; k < 16; k++) begin
            logic lo, hi, ri, fa;
            lo = k[0]; hi = k[1]; ri = k[2]; fa = k[3];
            wr(DLOW, N'(lo) << k); wr(DHIGH, N'(hi) << k);
            wr(DRISE, N'(ri) << k); wr(DFALL, N'(fa) << k);
            wr(STSA, '1); settle(5);
            rd(RAWA, d); exp = N'(lo) << k;
            chk(d == exp, "R7 low level at rest", d, exp);
            @(negedge clk); pad_in[k] = 1'b1; settle(6);
            rd(RAWA, d); exp = N'(lo | ri | hi) << k;
            chk(d == exp, "R5 rising and level", d, exp);
            wr(STSA, '1); settle(5);
            rd(RAWA, d); exp = N'(hi) << k;
            chk(d == exp, "R7 high level reasserts", d, exp);
            @(negedge clk); pad_in[k] = 1'b0; settle(6);
            rd(RAWA, d); exp = N'(hi | fa | lo) << k;
            chk(d == exp, "R6 falling and level", d, exp);
            wr(STSA, '1); settle(5);
            rd(RAWA, d); exp = N'(lo) << k;
            chk(d == exp, "R7 low level reasserts", d, exp);
            wr(DLOW, '0); wr(DHIGH, '0); wr(DRISE, '0); wr(DFALL, '0);
            wr(STSA, '1); settle(2);
            rd(RAWA, d); chk(d == '0, "R8 cleared after disable", d, 0);
        end

        // R8 hardware set and clear on the same edge
        wr(DRISE, 32'h1 << 20);
        wr(RAWA, 32'h1 << 20);
        @(negedge clk); pad_in[20] = 1'b1;
        repeat (3) @(negedge clk);
        wr_now(STSA, 32'h1 << 20);
        peek(RAWA, d); chk(d[20] == 1'b1, "R8 set wins over clear", d, 32'h1 << 20);
        wr(STSB, 32'h1 << 20);
        rd(RAWA, d); chk(d == '0, "R8 later clear removes bit", d, 0);
        wr(DRISE, '0);
        @(negedge clk); pad_in[20] = 1'b0; settle(5);
        rd(RAWA, d); chk(d == '0, "R8 no event after disable", d, 0);

        // R9 R10 R11 masks and lines
        for (int j = 0; j < 4; j++) begin
            p = 32'h0000_00FF << (j * 8);
            wr(STSA, '1);
            wr(ENAC, '1); wr(ENBC, '1); wr(WKC, '1);
            if (j[0]) wr(RAWB, p); else wr(RAWA, p);
            rd(RAWA, d); chk(d == p, "R11 software set", d, p);
            rd(RAWB, d); chk(d == p, "R11 both raw views", d, p);
            wr(ENAS, 32'h0F0F_0F0F); wr(ENAC, 32'h0000_FF00);
            wr(ENBS, 32'hF0F0_F0F0); wr(ENBC, 32'h00FF_0000);
            wr(WKS, 32'h3333_3333);  wr(WKC, 32'h0303_0303);
            ena = 32'h0F0F_0F0F & ~32'h0000_FF00;
            enb = 32'hF0F0_F0F0 & ~32'h00FF_0000;
            wk  = 32'h3333_3333 & ~32'h0303_0303;
            rd(ENAS, d); chk(d == ena, "R9 enable A value", d, ena);
            rd(ENBC, d); chk(d == enb, "R9 enable B value", d, enb);
            rd(STSA, d); chk(d == (p & ena), "R9 masked A", d, p & ena);
            rd(STSB, d); chk(d == (p & enb), "R9 masked B", d, p & enb);
            chk(irq_a == |(p & ena), "R9 irq_a", irq_a, |(p & ena));
            chk(irq_b == |(p & enb), "R9 irq_b", irq_b, |(p & enb));
            rd(WKS, d); chk(d == wk, "R10 wake enable value", d, wk);
            chk(wake_req == |(p & wk), "R10 wake_req", wake_req, |(p & wk));
        end
        wr(STSB, '1);
        chk({irq_a, irq_b, wake_req} == 3'b000, "R8 outputs drop after clear",
            {irq_a, irq_b, wake_req}, 0);

        // R12 debounce on pin 5, time 3, 8 clocks per tick
        wr(DBEN, 32'h1 << 5); wr(DBTIME, 32'd3);
        @(negedge clk); pad_in[5] = 1'b1;
        repeat (20) @(negedge clk);
        pad_in[5] = 1'b0; settle(8);
        rd(DIN, d); chk(d[5] == 1'b0, "R12 short pulse dropped", d, 0);
        @(negedge clk); pad_in[5] = 1'b1; settle(50);
        rd(DIN, d); chk(d[5] == 1'b1, "R12 long level accepted", d, 32'h1 << 5);
        @(negedge clk); pad_in[5] = 1'b0; settle(50);
        rd(DIN, d); chk(d[5] == 1'b0, "R12 release accepted", d, 0);

        // R13 soft reset
        wr(DOUT, 32'hDEAD_BEEF); wr(DIR, '0); wr(ENAS, 32'hFF); wr(RAWA, 32'hFF);
        wr(CFG, 32'h1);
        peek(STAT, d); chk(d[0] == 1'b0, "R13 not ready after request", d, 0);
        polls = 0;
        for (int t = 0; t < 20; t++) begin
            rd(STAT, d);
            polls++;
            if (d[0]) break;
        end
        chk(d[0] == 1'b1 && polls <= 6, "R13 ready again", polls, 6);
        rd(DOUT, d); chk(d == '0, "R13 dout restored", d, 0);
        rd(DIR, d);  chk(d == '1, "R13 dir restored", d, '1);
        rd(RAWA, d); chk(d == '0, "R13 events cleared", d, 0);
        rd(DBEN, d); chk(d == '0, "R13 debounce cleared", d, 0);
        chk(irq_a == 1'b0 && pad_oe == '0, "R13 outputs restored", {31'b0, irq_a}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule